// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block converts a 32-bit virtual address into a physical address by walking a two-level table held in memory. A translation request carries an address-space identifier (ASID), the virtual address and a read/write flag. The walker looks up the directory base word for that ASID and reads one directory entry. It then reads one table entry through a single-outstanding request/response memory port. It returns either the physical address or a fault code that names the level that refused the access.

The per-ASID directory base words sit in a small register bank. Software reaches the bank through an indirect pair: it first writes an ASID into a select register, then writes a data word that lands in the slot for that ASID. A global enable bit in a configuration word switches translation on. While that bit is clear, every request passes through untranslated. Only one walk is in flight at a time.

Top module: `xw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and translation is disabled.
- R2: With translation disabled, an accepted request returns `rsp_pa` equal to the virtual address zero-extended, with fault code 0 and no memory read, and `rsp_valid` is high in the cycle right after acceptance.
- R3: A configuration write with `cfg_sel`=0 sets the enable from bit 0. With `cfg_sel`=1 it loads the ASID select from bits 6:0. With `cfg_sel`=2 it stores the whole word as the base for the selected ASID. Slots are indexed by the low log2(NUM_ASID) ASID bits, so with 16 slots ASID 19 shares slot 3.
- R4: The directory read address is {base[PA_W-13:0], va[31:22], 2'b00}. The table read address is {dir_entry[PA_W-13:0], va[21:12], 2'b00}.
- R5: A successful walk returns {table_entry[PA_W-13:0], va[11:0]} with fault code 0. Table-entry bits from PA_W-12 up to 28 are ignored.
- R6: If the base word lacks the permission bit the access needs, the walk ends with fault code 1 and no memory read.
- R7: A directory entry with bit 28 (next-level) clear, or without the needed permission bit, ends the walk with fault code 2 after exactly one memory read.
- R8: A table entry equal to zero, or without the needed permission bit, ends the walk with fault code 3 after two memory reads.
- R9: A read access needs bit 31 and a write access needs bit 30 at every level. Bit 29 has no effect on the outcome.
- R10: From acceptance until the response handshake, `req_ready` stays low. A response waiting on `rsp_ready` holds its address and fault code. A memory request waiting on `mem_req_ready` holds its address.
- R11: The enable and base values are sampled when the request is accepted. A configuration write in that same cycle affects only later walks.
- R12: A faulting response carries `rsp_pa` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 config, 1 ASID select, 2 base data, 3 ignored |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_asid | input | 7 | Address-space identifier |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 for write access, 0 for read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_pa | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 0 ok, 1 base, 2 directory, 3 table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The case that matters most is a configuration write that lands in the same clock edge as a request acceptance. Two forms are covered: a base-data write that clears the slot of the ASID being accepted, and a config write that clears the enable. The bench raises the write strobe and `req_valid` together while the walker is idle, so both take effect on the same edge. It expects that walk to use the old settings, which shows up as a full two-read translation. It expects the following walk to use the new settings, which shows up as a base fault or a passthrough.

// File: rtl/xw_pkg.sv
package xw_pkg;

   localparam int ATTR_RD_BIT = 31;
   localparam int ATTR_WR_BIT = 30;
   localparam int ATTR_NS_BIT = 29;
   localparam int DIR_NEXT_BIT = 28;

   localparam logic [1:0] CFG_SEL_CTRL = 2'd0;
   localparam logic [1:0] CFG_SEL_ASID = 2'd1;
   localparam logic [1:0] CFG_SEL_BASE = 2'd2;

   typedef enum logic [1:0] {
      XW_OK       = 2'd0,
      XW_FLT_BASE = 2'd1,
      XW_FLT_DIR  = 2'd2,
      XW_FLT_TBL  = 2'd3
   } xw_fault_e;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_DIR_REQ,
      WK_DIR_WAIT,
      WK_TBL_REQ,
      WK_TBL_WAIT,
      WK_RESP
   } wk_state_e;

endpackage

// File: rtl/xw_ctx_bank.sv
module xw_ctx_bank
   import xw_pkg::*;
#(
   parameter int NUM_ASID = 16,
   parameter int ASID_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic [ASID_W-1:0] rd_asid,
   output logic              xlate_en,
   output logic [31:0]       rd_base
);

   localparam int IDX_W = $clog2(NUM_ASID);

   generate
      if (NUM_ASID < 2 || NUM_ASID > (1 << ASID_W)) begin : g_bad_depth
         $error("xw_ctx_bank: NUM_ASID out of range");
      end
   endgenerate

   logic              en_q;
   logic [ASID_W-1:0] sel_q;
   logic [31:0]       slot_q [NUM_ASID];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_SEL_CTRL) en_q  <= cfg_wdata[0];
         if (cfg_sel == CFG_SEL_ASID) sel_q <= cfg_wdata[ASID_W-1:0];
      end
   end

   generate
      for (genvar g = 0; g < NUM_ASID; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (cfg_we && cfg_sel == CFG_SEL_BASE &&
                     sel_q[IDX_W-1:0] == IDX_W'(g))
               slot_q[g] <= cfg_wdata;
         end
      end
   endgenerate

   assign xlate_en = en_q;
   assign rd_base  = slot_q[rd_asid[IDX_W-1:0]];

   // R3
   asid_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_sel == CFG_SEL_ASID |=> sel_q == $past(cfg_wdata[ASID_W-1:0]));

   // R3
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_sel == CFG_SEL_CTRL |=> xlate_en == $past(cfg_wdata[0]));

endmodule

// File: rtl/xw_perm.sv
module xw_perm
   import xw_pkg::*;
#(
   parameter bit NEED_NEXT    = 1'b0,
   parameter bit NEED_NONZERO = 1'b0
) (
   input  logic [31:0] entry,
   input  logic        is_write,
   output logic        ok
);

   logic rw_ok;
   logic lvl_ok;

   assign rw_ok = is_write ? entry[ATTR_WR_BIT] : entry[ATTR_RD_BIT];

   generate
      if (NEED_NEXT && NEED_NONZERO) begin : g_both
         assign lvl_ok = entry[DIR_NEXT_BIT] && (entry != '0);
      end else if (NEED_NEXT) begin : g_next
         assign lvl_ok = entry[DIR_NEXT_BIT];
      end else if (NEED_NONZERO) begin : g_nz
         assign lvl_ok = (entry != '0);
      end else begin : g_none
         assign lvl_ok = 1'b1;
      end
   endgenerate

   assign ok = rw_ok && lvl_ok;

endmodule

// File: rtl/xw_walker.sv
module xw_walker
   import xw_pkg::*;
#(
   parameter int PA_W     = 34,
   parameter int NUM_ASID = 16,
   parameter int ASID_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [31:0]       req_va,
   input  logic              req_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [1:0]        rsp_fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data
);

   localparam int PFN_W = PA_W - 12;

   generate
      if (PA_W < 32 || PA_W > 40) begin : g_bad_pa
         $error("xw_walker: PA_W must lie in 32..40");
      end
   endgenerate

   wk_state_e          state_q;
   logic [31:0]        va_q;
   logic               wr_q;
   logic [PA_W-1:0]    addr_q;
   logic [PA_W-1:0]    pa_q;
   xw_fault_e          flt_q;

   logic               xlate_en;
   logic [31:0]        sel_base;
   logic               base_ok;
   logic               dir_ok;
   logic               tbl_ok;
   logic               accept;

   xw_ctx_bank #(.NUM_ASID(NUM_ASID), .ASID_W(ASID_W)) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .rd_asid   (req_asid),
      .xlate_en  (xlate_en),
      .rd_base   (sel_base)
   );

   xw_perm #(.NEED_NEXT(1'b0), .NEED_NONZERO(1'b0)) i_base_perm (
      .entry (sel_base), .is_write (req_write), .ok (base_ok));

   xw_perm #(.NEED_NEXT(1'b1), .NEED_NONZERO(1'b0)) i_dir_perm (
      .entry (mem_rsp_data), .is_write (wr_q), .ok (dir_ok));

   xw_perm #(.NEED_NEXT(1'b0), .NEED_NONZERO(1'b1)) i_tbl_perm (
      .entry (mem_rsp_data), .is_write (wr_q), .ok (tbl_ok));

   assign accept = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         pa_q    <= '0;
         flt_q   <= XW_OK;
      end else begin
         unique case (state_q)
            WK_IDLE: begin
               if (accept) begin
                  va_q <= req_va;
                  wr_q <= req_write;
                  if (!xlate_en) begin
                     pa_q    <= PA_W'(req_va);
                     flt_q   <= XW_OK;
                     state_q <= WK_RESP;
                  end else if (!base_ok) begin
                     pa_q    <= '0;
                     flt_q   <= XW_FLT_BASE;
                     state_q <= WK_RESP;
                  end else begin
                     addr_q  <= {sel_base[PFN_W-1:0], req_va[31:22], 2'b00};
                     state_q <= WK_DIR_REQ;
                  end
               end
            end
            WK_DIR_REQ: if (mem_req_ready) state_q <= WK_DIR_WAIT;
            WK_DIR_WAIT: begin
               if (mem_rsp_valid) begin
                  if (dir_ok) begin
                     addr_q  <= {mem_rsp_data[PFN_W-1:0], va_q[21:12], 2'b00};
                     state_q <= WK_TBL_REQ;
                  end else begin
                     pa_q    <= '0;
                     flt_q   <= XW_FLT_DIR;
                     state_q <= WK_RESP;
                  end
               end
            end
            WK_TBL_REQ: if (mem_req_ready) state_q <= WK_TBL_WAIT;
            WK_TBL_WAIT: begin
               if (mem_rsp_valid) begin
                  if (tbl_ok) begin
                     pa_q  <= {mem_rsp_data[PFN_W-1:0], va_q[11:0]};
                     flt_q <= XW_OK;
                  end else begin
                     pa_q  <= '0;
                     flt_q <= XW_FLT_TBL;
                  end
                  state_q <= WK_RESP;
               end
            end
            WK_RESP: if (rsp_ready) state_q <= WK_IDLE;
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == WK_IDLE);
   assign rsp_valid     = (state_q == WK_RESP);
   assign rsp_pa        = pa_q;
   assign rsp_fault     = flt_q;
   assign mem_req_valid = (state_q == WK_DIR_REQ) || (state_q == WK_TBL_REQ);
   assign mem_req_addr  = addr_q;

   // R10
   one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R12
   fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != XW_OK |-> rsp_pa == '0);

   // R2
   pass_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !xlate_en |=> rsp_valid && rsp_pa == PA_W'($past(req_va)));

   // R6
   base_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && xlate_en && !base_ok |=> rsp_valid && !mem_req_valid);

endmodule

// File: tb/test_xw_walker.sv
`timescale 1ns/1ps
module test_xw_walker;

   localparam int CLK_PERIOD = 10;
   localparam int PA_W = 34;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_sel = '0;
   logic [31:0]     cfg_wdata = '0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [6:0]      req_asid = '0;
   logic [31:0]     req_va = '0;
   logic            req_write = 1'b0;
   logic            rsp_valid;
   logic            rsp_ready = 1'b1;
   logic [PA_W-1:0] rsp_pa;
   logic [1:0]      rsp_fault;
   logic            mem_req_valid;
   logic            mem_req_ready = 1'b0;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_rsp_valid = 1'b0;
   logic [31:0]     mem_rsp_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xw_walker #(.PA_W(PA_W), .NUM_ASID(16), .ASID_W(7)) i_xw_walker (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
      .req_valid (req_valid), .req_ready (req_ready), .req_asid (req_asid),
      .req_va (req_va), .req_write (req_write),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_pa (rsp_pa),
      .rsp_fault (rsp_fault),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data)
   );

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0]     mem [logic [PA_W-1:0]];
   logic [PA_W-1:0] rd_q [$];
   int mem_stall = 0;
   int mem_lat = 0;

   function automatic logic [31:0] rdmem(logic [PA_W-1:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            for (int s = 0; s < mem_stall; s++) @(negedge clk);
            mem_req_ready = 1'b1;
            rd_q.push_back(mem_req_addr);
            mem_rsp_data = rdmem(mem_req_addr);
            @(posedge clk); #2;
            mem_req_ready = 1'b0;
            for (int l = 0; l < mem_lat; l++) begin @(posedge clk); #2; end
            mem_rsp_valid = 1'b1;
            @(posedge clk); #2;
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [PA_W-1:0] ex_pa [$];
   logic [1:0]      ex_flt [$];
   int              ex_nrd [$];
   logic [PA_W-1:0] ex_a0 [$];
   logic [PA_W-1:0] ex_a1 [$];
   string           ex_tag [$];

   task automatic expect_xl(string tag, logic [PA_W-1:0] pa, logic [1:0] flt,
                            int nrd, logic [PA_W-1:0] a0, logic [PA_W-1:0] a1);
      ex_pa.push_back(pa);  ex_flt.push_back(flt); ex_nrd.push_back(nrd);
      ex_a0.push_back(a0);  ex_a1.push_back(a1);   ex_tag.push_back(tag);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rsp_valid && rsp_ready) begin
            if (ex_pa.size() == 0) begin
               check("R10 unexpected response", 64'(rsp_pa), 64'hDEAD);
            end else begin
               string t;
               int n;
               t = ex_tag.pop_front();
               n = ex_nrd.pop_front();
               check({t, " pa"}, 64'(rsp_pa), 64'(ex_pa.pop_front()));
               check({t, " fault"}, 64'(rsp_fault), 64'(ex_flt.pop_front()));
               check({t, " reads"}, 64'(rd_q.size()), 64'(n));
               if (n >= 1 && rd_q.size() >= 1)
                  check({t, " R4 dir addr"}, 64'(rd_q[0]), 64'(ex_a0[0]));
               if (n >= 2 && rd_q.size() >= 2)
                  check({t, " R4 tbl addr"}, 64'(rd_q[1]), 64'(ex_a1[0]));
               void'(ex_a0.pop_front());
               void'(ex_a1.pop_front());
               rd_q.delete();
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic cfg(logic [1:0] sel, logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic send(logic [6:0] asid, logic [31:0] va, logic wr);
      req_asid = asid; req_va = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      tick();
      req_valid = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (ex_pa.size() != 0) @(negedge clk);
      tick();
   endtask

   function automatic logic [PA_W-1:0] dir_addr(logic [31:0] b, logic [31:0] va);
      return {b[PA_W-13:0], va[31:22], 2'b00};
   endfunction
   function automatic logic [PA_W-1:0] tbl_addr(logic [31:0] d, logic [31:0] va);
      return {d[PA_W-13:0], va[21:12], 2'b00};
   endfunction
   function automatic logic [PA_W-1:0] pa_of(logic [31:0] t, logic [31:0] va);
      return {t[PA_W-13:0], va[11:0]};
   endfunction

   localparam logic [31:0] B3   = 32'hE000_0100;
   localparam logic [31:0] VA1  = 32'h1234_5678;
   localparam logic [31:0] VA2  = 32'h1234_9ABC;
   localparam logic [31:0] VA3  = 32'h1235_0000;
   localparam logic [31:0] VA4  = 32'h1240_0ABC;
   localparam logic [31:0] VA5  = 32'h1280_5678;
   localparam logic [31:0] PDE1 = 32'hD000_0200;
   localparam logic [31:0] PDE4 = 32'hC000_0300;
   localparam logic [31:0] PDE5 = 32'h9000_0200;
   localparam logic [31:0] PTE1 = 32'hC203_ABCD;
   localparam logic [31:0] PTE2 = 32'h8000_0055;
   localparam logic [31:0] PTE5 = 32'hC03F_FFFF;

   initial begin
      logic [PA_W-1:0] held_pa;
      mem[dir_addr(B3, VA1)] = PDE1;
      mem[tbl_addr(PDE1, VA1)] = PTE1;
      mem[tbl_addr(PDE1, VA2)] = PTE2;
      mem[dir_addr(B3, VA4)] = PDE4;
      mem[dir_addr(B3, VA5)] = PDE5;
      mem[tbl_addr(PDE5, VA5)] = PTE5;

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 req_ready", 64'(req_ready), 64'd1);
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      tick();

      // R1 / R2 disabled after reset: passthrough, fast response
      expect_xl("R2 passthrough", PA_W'(32'h8765_4321), 2'd0, 0, '0, '0);
      send(7'd3, 32'h8765_4321, 1'b0);
      @(negedge clk);
      check("R2 response next cycle", 64'(rsp_valid), 64'd1);
      drain();

      // R3 program slot 3, enable
      cfg(2'd1, 32'd3);
      cfg(2'd2, B3);
      cfg(2'd0, 32'd1);

      // R5 R9 read and write translate; bit 29 set only in base
      expect_xl("R5 read walk", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd3, VA1, 1'b0);
      drain();
      check("R5 high pte bits masked", 64'(pa_of(PTE1, VA1)), 64'h3ABCD678);
      expect_xl("R9 write walk", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd3, VA1, 1'b1);
      drain();

      // R3 aliasing: ASID 19 uses slot 3
      expect_xl("R3 alias slot", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd19, VA1, 1'b0);
      drain();

      // R8 R9 read-only table entry
      expect_xl("R9 ro pte read", pa_of(PTE2, VA2), 2'd0, 2,
                dir_addr(B3, VA2), tbl_addr(PDE1, VA2));
      send(7'd3, VA2, 1'b0);
      drain();
      expect_xl("R8 ro pte write R12", '0, 2'd3, 2,
                dir_addr(B3, VA2), tbl_addr(PDE1, VA2));
      send(7'd3, VA2, 1'b1);
      drain();

      // R8 zero entry
      expect_xl("R8 unmapped", '0, 2'd3, 2,
                dir_addr(B3, VA3), tbl_addr(PDE1, VA3));
      send(7'd3, VA3, 1'b0);
      drain();

      // R7 next-level bit clear
      expect_xl("R7 no next", '0, 2'd2, 1, dir_addr(B3, VA4), '0);
      send(7'd3, VA4, 1'b0);
      drain();

      // R7 read-only directory entry
      expect_xl("R7 ro dir write", '0, 2'd2, 1, dir_addr(B3, VA5), '0);
      send(7'd3, VA5, 1'b1);
      drain();
      expect_xl("R9 ro dir read", pa_of(PTE5, VA5), 2'd0, 2,
                dir_addr(B3, VA5), tbl_addr(PDE5, VA5));
      send(7'd3, VA5, 1'b0);
      drain();

      // R6 empty slot and read-only base
      expect_xl("R6 empty base", '0, 2'd1, 0, '0, '0);
      send(7'd5, VA1, 1'b0);
      drain();
      cfg(2'd1, 32'd6);
      cfg(2'd2, 32'h8000_0100);
      expect_xl("R6 ro base write", '0, 2'd1, 0, '0, '0);
      send(7'd6, VA1, 1'b1);
      drain();
      expect_xl("R9 ro base read", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd6, VA1, 1'b0);
      drain();

      // R10 memory back-pressure
      mem_stall = 2; mem_lat = 3;
      expect_xl("R10 mem stall", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd3, VA1, 1'b0);
      drain();
      mem_stall = 0; mem_lat = 0;

      // R10 response back-pressure
      rsp_ready = 1'b0;
      expect_xl("R10 rsp held", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd3, VA1, 1'b0);
      req_valid = 1'b1;
      @(negedge clk);
      while (!rsp_valid) @(negedge clk);
      held_pa = rsp_pa;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R10 busy req_ready", 64'(req_ready), 64'd0);
         check("R10 rsp stable", 64'(rsp_pa), 64'(held_pa));
      end
      req_valid = 1'b0;
      tick();
      rsp_ready = 1'b1;
      drain();

      // R11 base write in acceptance cycle
      cfg(2'd1, 32'd7);
      cfg(2'd2, B3);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0;
      expect_xl("R11 old base used", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd7, VA1, 1'b0);
      drain();
      expect_xl("R11 new base used", '0, 2'd1, 0, '0, '0);
      send(7'd7, VA1, 1'b0);
      drain();

      // R11 disable in acceptance cycle
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0;
      expect_xl("R11 still enabled", pa_of(PTE1, VA1), 2'd0, 2,
                dir_addr(B3, VA1), tbl_addr(PDE1, VA1));
      send(7'd3, VA1, 1'b0);
      drain();
      expect_xl("R11 now passthrough", PA_W'(VA1), 2'd0, 0, '0, '0);
      send(7'd3, VA1, 1'b0);
      drain();

      // R3 unused select code leaves state alone
      cfg(2'd3, 32'h1);
      expect_xl("R3 sel 3 ignored", PA_W'(VA2), 2'd0, 0, '0, '0);
      send(7'd3, VA2, 1'b1);
      drain();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule